// File: doc/BRIEF.md
# Dual Interval Timer with Cascade Option

This block holds two up-counting interval timers of `CNT_W` bits. Each timer counts ticks from a source chosen in a mode byte: the system clock divided by `DIV_A` (12 by default), divided by `DIV_B` (384 by default), rising edges on an external count pin, or, for timer 1 only, the match events of timer 0. A timer that reaches its compare value returns to zero in the same step and raises its own interrupt flag. The flag stays up until software clears it with a write-one-to-clear strobe. A single toggle output flips on the matches of one timer, chosen by the mode byte.

Each timer's source is a small state held in the mode register. The states are SRC_DIV_A, SRC_DIV_B, SRC_EXT, SRC_CHAIN (timer 1 only) and SRC_OFF (timer 0 only). The toggle output has three states: TOG_T0, TOG_T1 and TOG_HOLD. A mode write is the only transition. It moves each timer, and the toggle selector, straight to the state that its field encodes, and the new state takes effect from the cycle after the write. Each prescaler keeps its residue when the source changes. If the residue is already at or past the new divide ratio, the timer ticks on every cycle and the ratio is subtracted each time, until the residue falls below the ratio. Compare writes also take effect from the next cycle.

Top module: `dual_itimer`

## Requirements
- R1: While reset is low and just after it is released, `irq0`, `irq1` and `tog_out` are 0, both counters are 0, and the mode and compare registers are 0.
- R2: Mode bits 3:2 select the source of timer 0. 00 is clock/12, 01 is clock/384, 10 is the external pin, and 11 stops the timer. With a divided source selected from reset, the first match is `div*cmp` cycles after release.
- R3: Mode bits 6:5 select the source of timer 1. 00 is clock/12, 01 is clock/384, 10 is the external pin, and 11 is cascade from timer 0.
- R4: On each tick the counter adds one. If the new value equals the compare register, the counter becomes 0 and a match occurs. A compare value of 0 gives a period of 2^CNT_W ticks.
- R5: A match sets that timer's flag. `flag_clr` bit 0 clears `irq0` and bit 1 clears `irq1`. A bit clears only its own flag, and a match in the same cycle wins over the clear.
- R6: Mode bits 1:0 select the toggle source. 00 flips `tog_out` on each timer 0 match, 01 flips it on each timer 1 match, and 10 or 11 hold it.
- R7: In cascade mode, timer 1 advances by one only in cycles where timer 0 matches.
- R8: `ext_cnt` passes through two synchroniser flops. Each rising edge is one tick, however long the pin stays high. The counter update lands on the third clock edge after the pin rises.
- R9: The prescaler residue is not cleared on a source change. After a switch from clock/384 to clock/12 with a residue above 11, the timer ticks on every cycle until the residue drops below 12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_we | input | 1 | Write strobe for the mode byte |
| mode_wdata | input | 8 | Mode byte (bits 4 and 7 unused) |
| cmp0_we | input | 1 | Write strobe for the timer 0 compare value |
| cmp0_wdata | input | CNT_W | Timer 0 compare value |
| cmp1_we | input | 1 | Write strobe for the timer 1 compare value |
| cmp1_wdata | input | CNT_W | Timer 1 compare value |
| ext_cnt | input | 1 | External count pin, asynchronous |
| flag_clr | input | 2 | Write-one-to-clear strobes for the two flags |
| irq0 | output | 1 | Timer 0 interrupt flag |
| irq1 | output | 1 | Timer 1 interrupt flag |
| tog_out | output | 1 | Toggle flip-flop output |

## Verification
The assertions check several rules on every cycle. A flag holds until its own clear bit arrives, and every match sets its flag. A counter is zero right after a match. The toggle output moves only on a match and never in a hold state. In cascade mode, timer 1 does not change in any cycle without a timer 0 match. Only the directed scenarios can show the exact cycle counts: the divide ratios, the wrap period at compare zero, the three-edge latency of the external pin, the one-tick-per-edge rule for a held pin, and the catch-up ticks after a prescaler switch.

// File: rtl/dit_pkg.sv
package dit_pkg;

    // clock source of one interval timer, decoded from its mode field
    typedef enum logic [2:0] {
        SRC_DIV_A,
        SRC_DIV_B,
        SRC_EXT,
        SRC_CHAIN,
        SRC_OFF
    } src_e;

    // which match events flip the shared toggle output
    typedef enum logic [1:0] {
        TOG_T0,
        TOG_T1,
        TOG_HOLD
    } tog_e;

    localparam int TOG_LSB = 0;
    localparam int T0_LSB  = 2;
    localparam int T1_LSB  = 5;

    function automatic src_e decode_t0(input logic [1:0] f);
        unique case (f)
            2'b00:   return SRC_DIV_A;
            2'b01:   return SRC_DIV_B;
            2'b10:   return SRC_EXT;
            default: return SRC_OFF;
        endcase
    endfunction

    function automatic src_e decode_t1(input logic [1:0] f);
        unique case (f)
            2'b00:   return SRC_DIV_A;
            2'b01:   return SRC_DIV_B;
            2'b10:   return SRC_EXT;
            default: return SRC_CHAIN;
        endcase
    endfunction

    function automatic tog_e decode_tog(input logic [1:0] f);
        unique case (f)
            2'b00:   return TOG_T0;
            2'b01:   return TOG_T1;
            default: return TOG_HOLD;
        endcase
    endfunction

endpackage

// File: rtl/dit_prescaler.sv
module dit_prescaler #(
    parameter int DIV_A = 12,
    parameter int DIV_B = 384
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic use_b,
    output logic tick
);
    localparam int RW = $clog2(DIV_B + 1);
    localparam int NW = RW + 1;

    logic [RW-1:0] res_q;
    logic [NW-1:0] nxt;
    logic [NW-1:0] lim;

    always_comb begin
        nxt  = {1'b0, res_q} + NW'(1);
        lim  = use_b ? NW'(DIV_B) : NW'(DIV_A);
        tick = run && (nxt >= lim);
    end

    // the residue survives a ratio change; an excess drains one tick per cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
        end else if (run) begin
            if (tick) res_q <= RW'(nxt - lim);
            else      res_q <= RW'(nxt);
        end
    end
endmodule

// File: rtl/dit_edge_sync.sv
module dit_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);
    logic [STAGES:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[STAGES-1:0], din};
    end

    assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/dit_counter.sv
module dit_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic [W-1:0] cmp,
    input  logic         flag_clr,
    output logic [W-1:0] cnt,
    output logic         match,
    output logic         flag
);
    logic [W-1:0] cnt_q;
    logic [W-1:0] inc;

    always_comb begin
        inc   = cnt_q + W'(1);
        match = tick && (inc == cmp);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            flag  <= 1'b0;
        end else begin
            if (tick) cnt_q <= match ? '0 : inc;
            if (match)         flag <= 1'b1;
            else if (flag_clr) flag <= 1'b0;
        end
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/dual_itimer.sv
module dual_itimer
    import dit_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int DIV_A       = 12,
    parameter int DIV_B       = 384,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_we,
    input  logic [7:0]       mode_wdata,
    input  logic             cmp0_we,
    input  logic [CNT_W-1:0] cmp0_wdata,
    input  logic             cmp1_we,
    input  logic [CNT_W-1:0] cmp1_wdata,
    input  logic             ext_cnt,
    input  logic [1:0]       flag_clr,
    output logic             irq0,
    output logic             irq1,
    output logic             tog_out
);
    localparam int NT = 2;

    logic [1:0]       t0_sel_q, t1_sel_q, tog_sel_q;
    logic [CNT_W-1:0] cmp0_q, cmp1_q;
    logic             unused_mode_bits;

    src_e src0, src1;
    tog_e tog_src;

    logic             pre_run  [NT];
    logic             pre_useb [NT];
    logic             pre_tick [NT];
    logic             ext_rise;
    logic             tick0, tick1, match0, match1;
    logic [CNT_W-1:0] t0_cnt, t1_cnt;
    logic             tog_q;

    assign unused_mode_bits = mode_wdata[4] ^ mode_wdata[7];

    // state register: mode fields and compare values
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t0_sel_q  <= 2'b00;
            t1_sel_q  <= 2'b00;
            tog_sel_q <= 2'b00;
            cmp0_q    <= '0;
            cmp1_q    <= '0;
        end else begin
            if (mode_we) begin
                t0_sel_q  <= mode_wdata[T0_LSB +: 2];
                t1_sel_q  <= mode_wdata[T1_LSB +: 2];
                tog_sel_q <= mode_wdata[TOG_LSB +: 2];
            end
            if (cmp0_we) cmp0_q <= cmp0_wdata;
            if (cmp1_we) cmp1_q <= cmp1_wdata;
        end
    end

    always_comb begin
        src0    = decode_t0(t0_sel_q);
        src1    = decode_t1(t1_sel_q);
        tog_src = decode_tog(tog_sel_q);
    end

    // prescaler controls for both timers
    always_comb begin
        pre_run[0]  = (src0 == SRC_DIV_A) || (src0 == SRC_DIV_B);
        pre_useb[0] = (src0 == SRC_DIV_B);
        pre_run[1]  = (src1 == SRC_DIV_A) || (src1 == SRC_DIV_B);
        pre_useb[1] = (src1 == SRC_DIV_B);
    end

    for (genvar gi = 0; gi < NT; gi++) begin : g_pre
        dit_prescaler #(.DIV_A(DIV_A), .DIV_B(DIV_B)) u_pre (
            .clk   (clk),
            .rst_n (rst_n),
            .run   (pre_run[gi]),
            .use_b (pre_useb[gi]),
            .tick  (pre_tick[gi])
        );
    end

    dit_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (ext_cnt),
        .rise  (ext_rise)
    );

    // tick selection from the source state of each timer
    always_comb begin
        unique case (src0)
            SRC_DIV_A, SRC_DIV_B: tick0 = pre_tick[0];
            SRC_EXT:              tick0 = ext_rise;
            default:              tick0 = 1'b0;
        endcase
    end

    always_comb begin
        unique case (src1)
            SRC_DIV_A, SRC_DIV_B: tick1 = pre_tick[1];
            SRC_EXT:              tick1 = ext_rise;
            SRC_CHAIN:            tick1 = match0;
            default:              tick1 = 1'b0;
        endcase
    end

    dit_counter #(.W(CNT_W)) u_cnt0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick0),
        .cmp      (cmp0_q),
        .flag_clr (flag_clr[0]),
        .cnt      (t0_cnt),
        .match    (match0),
        .flag     (irq0)
    );

    dit_counter #(.W(CNT_W)) u_cnt1 (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick1),
        .cmp      (cmp1_q),
        .flag_clr (flag_clr[1]),
        .cnt      (t1_cnt),
        .match    (match1),
        .flag     (irq1)
    );

    // output process: shared toggle flip-flop
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tog_q <= 1'b0;
        end else begin
            unique case (tog_src)
                TOG_T0:  if (match0) tog_q <= ~tog_q;
                TOG_T1:  if (match1) tog_q <= ~tog_q;
                default: tog_q <= tog_q;
            endcase
        end
    end

    assign tog_out = tog_q;
endmodule

// File: rtl/dit_checker.sv
module dit_checker #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             irq0,
    input logic             irq1,
    input logic             tog_out,
    input logic [1:0]       flag_clr,
    input logic             match0,
    input logic             match1,
    input logic [CNT_W-1:0] cnt0,
    input logic [CNT_W-1:0] cnt1,
    input logic [1:0]       t1_sel,
    input logic [1:0]       tog_sel
);
    // R5
    flag0_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq0 && !flag_clr[0] |=> irq0);

    // R5
    flag1_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq1 && !flag_clr[1] |=> irq1);

    // R5
    flag0_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        match0 |=> irq0);

    // R5
    flag1_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        match1 |=> irq1);

    // R4
    wrap0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        match0 |=> cnt0 == '0);

    // R4
    wrap1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        match1 |=> cnt1 == '0);

    // R6
    tog_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tog_sel[1] |=> $stable(tog_out));

    // R6
    tog_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !match0 && !match1 |=> $stable(tog_out));

    // R7
    chain_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (t1_sel == 2'b11) && !match0 |=> $stable(cnt1));
endmodule

bind dual_itimer dit_checker #(.CNT_W(CNT_W)) u_dit_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq0     (irq0),
    .irq1     (irq1),
    .tog_out  (tog_out),
    .flag_clr (flag_clr),
    .match0   (match0),
    .match1   (match1),
    .cnt0     (t0_cnt),
    .cnt1     (t1_cnt),
    .t1_sel   (t1_sel_q),
    .tog_sel  (tog_sel_q)
);

// File: tb/test_dual_itimer.sv
module test_dual_itimer;
    localparam int CLK_PERIOD = 10;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         mode_we = 1'b0;
    logic [7:0]   mode_wdata = '0;
    logic         cmp0_we = 1'b0;
    logic [W-1:0] cmp0_wdata = '0;
    logic         cmp1_we = 1'b0;
    logic [W-1:0] cmp1_wdata = '0;
    logic         ext_cnt = 1'b0;
    logic [1:0]   flag_clr = '0;
    logic         irq0, irq1, tog_out;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_itimer i_dual_itimer (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_we    (mode_we),
        .mode_wdata (mode_wdata),
        .cmp0_we    (cmp0_we),
        .cmp0_wdata (cmp0_wdata),
        .cmp1_we    (cmp1_we),
        .cmp1_wdata (cmp1_wdata),
        .ext_cnt    (ext_cnt),
        .flag_clr   (flag_clr),
        .irq0       (irq0),
        .irq1       (irq1),
        .tog_out    (tog_out)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // reset, then load mode and compares in the release cycle; returns at cycle 1
    task automatic start(input logic [7:0] m, input logic [W-1:0] c0, input logic [W-1:0] c1);
        @(negedge clk);
        rst_n = 1'b0; ext_cnt = 1'b0; flag_clr = '0;
        mode_we = 1'b0; cmp0_we = 1'b0; cmp1_we = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        mode_we = 1'b1; mode_wdata = m;
        cmp0_we = 1'b1; cmp0_wdata = c0;
        cmp1_we = 1'b1; cmp1_wdata = c1;
        @(negedge clk);
        mode_we = 1'b0; cmp0_we = 1'b0; cmp1_we = 1'b0;
    endtask

    task automatic wait_flag(input int which, input int limit, inout int k);
        while (k < limit && !(which == 0 ? irq0 : irq1)) begin
            @(negedge clk);
            k++;
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1", "irq0 in reset", int'(irq0), 0);
        chk("R1", "irq1 in reset", int'(irq1), 0);
        chk("R1", "tog in reset", int'(tog_out), 0);
    endtask

    task automatic t_div12_and_clear();
        int k;
        start(8'h00, 8'd3, 8'd200);
        k = 1;
        wait_flag(0, 1000, k);
        chk("R2", "t0 /12 first match cycle", k, 36);
        chk("R6", "tog after t0 match", int'(tog_out), 1);
        repeat (10) @(negedge clk);
        chk("R5", "irq0 held", int'(irq0), 1);
        flag_clr = 2'b10;
        @(negedge clk);
        flag_clr = 2'b01;
        chk("R5", "irq0 after other clear bit", int'(irq0), 1);
        chk("R5", "irq1 untouched", int'(irq1), 0);
        @(negedge clk);
        flag_clr = 2'b00;
        chk("R5", "irq0 after clear", int'(irq0), 0);
        k = 48;
        wait_flag(0, 1000, k);
        chk("R4", "t0 second match cycle", k, 72);
        chk("R6", "tog after second match", int'(tog_out), 0);
    endtask

    task automatic t_div384();
        int k;
        start(8'h04, 8'd2, 8'd0);
        k = 1;
        wait_flag(0, 2000, k);
        chk("R2", "t0 /384 match cycle", k, 768);
    endtask

    task automatic t_cmp_zero();
        int k;
        start(8'h00, 8'd0, 8'd0);
        k = 1;
        wait_flag(0, 5000, k);
        chk("R4", "compare zero wraps at 256 ticks", k, 3072);
    endtask

    task automatic t_timer1_div12();
        int k;
        start(8'h0D, 8'd1, 8'd5);
        k = 1;
        wait_flag(1, 1000, k);
        chk("R3", "t1 /12 match cycle", k, 60);
        chk("R2", "t0 stopped keeps irq0 low", int'(irq0), 0);
        chk("R6", "tog on t1 match", int'(tog_out), 1);
    endtask

    task automatic t_timer1_div384_hold();
        int k;
        start(8'h2F, 8'd1, 8'd1);
        k = 1;
        wait_flag(1, 2000, k);
        chk("R3", "t1 /384 match cycle", k, 384);
        chk("R6", "tog held in mode 11", int'(tog_out), 0);
    endtask

    task automatic t_cascade();
        int k;
        start(8'h61, 8'd2, 8'd3);
        k = 1;
        wait_flag(0, 1000, k);
        chk("R7", "t0 match cycle in cascade", k, 24);
        chk("R7", "t1 not yet matched", int'(irq1), 0);
        chk("R6", "tog waits for t1", int'(tog_out), 0);
        wait_flag(1, 1000, k);
        chk("R7", "t1 match after three t0 matches", k, 72);
        chk("R6", "tog on cascaded match", int'(tog_out), 1);
    endtask

    task automatic pulse(input int hi, input int lo);
        ext_cnt = 1'b1;
        repeat (hi) @(negedge clk);
        ext_cnt = 1'b0;
        repeat (lo) @(negedge clk);
    endtask

    task automatic t_external();
        start(8'h48, 8'd3, 8'd4);
        pulse(2, 3);
        pulse(2, 3);
        chk("R8", "irq0 after two edges", int'(irq0), 0);
        ext_cnt = 1'b1;
        repeat (2) @(negedge clk);
        chk("R8", "irq0 two cycles after third edge", int'(irq0), 0);
        @(negedge clk);
        chk("R8", "irq0 three cycles after third edge", int'(irq0), 1);
        repeat (20) @(negedge clk);
        ext_cnt = 1'b0;
        repeat (3) @(negedge clk);
        chk("R8", "long high counted once", int'(irq1), 0);
        pulse(2, 4);
        chk("R8", "irq1 after fourth edge", int'(irq1), 1);
    endtask

    task automatic t_residue();
        int k;
        start(8'h04, 8'd1, 8'd0);
        repeat (99) @(negedge clk);
        mode_we = 1'b1; mode_wdata = 8'h00;
        @(negedge clk);
        mode_we = 1'b0;
        k = 101;
        wait_flag(0, 1000, k);
        chk("R9", "first tick after /384 to /12 switch", k, 102);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_div12_and_clear();
        t_div384();
        t_cmp_zero();
        t_timer1_div12();
        t_timer1_div384_hold();
        t_cascade();
        t_external();
        t_residue();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule